// File: doc/BRIEF.md
# Clock-Enabled Bus Master Bridge

This block sits between a fast processor core and a slower AHB system bus. The two run from one rising-edge clock. A one-cycle enable pulse, `hclk_en`, marks the fast-clock edges that are also bus-clock edges. Every bus action is taken only on those marked edges: the address phase is driven on them, and the slave's answers are sampled on them.

The core presents one request at a time and holds it steady until `core_en` is high at a clock edge. Requests fall into three kinds, set by `req_local`, `req_write` and `req_buf`:
- A local tightly-coupled memory access goes out on `tcm_sel` and never waits for the bus.
- A buffered write goes to the write buffer on `wb_push`. It stalls the core only while `wb_full` reports no room.
- Any other request is a bus read or an unbuffered write.

A bus read or unbuffered write drops `core_en` in the cycle the request appears. The block then waits for the next enable pulse and runs one single-beat transfer. In the cycle after the data phase ends, it gives read data and an error flag back to the core and raises `core_en` again.

Top module: `ahb_ce_master`

## Requirements
- R1: After reset, with no request present, `core_en` is 1, `htrans` is IDLE (2'b00) and `rsp_abort` is 0.
- R2: `htrans` changes only at a clock edge that ends a cycle in which `hclk_en` was 1.
- R3: A bus transfer drives `htrans` = NONSEQ (2'b10) together with `haddr`, `hwrite`, `hsize` and `hprot` copied from the request. `htrans` goes back to IDLE at the first edge where both `hclk_en` and `hready` are 1.
- R4: The data phase ends only at an edge where `hready` and `hclk_en` are both 1. While either is low, the core stays stalled.
- R5: `core_en` is 0 in every cycle from the cycle a bus request appears until the data phase ends. It is 1 in the single response cycle that follows.
- R6: The number of stalled cycles for a bus request is d + 1 + N·(W + 2). Here N is the clock ratio, W is the number of slave wait states, and d (0 to N−1) is the number of cycles from the request cycle to the next cycle with `hclk_en` high.
- R7: For a write, `hwdata` carries the request data from the edge that ends the address phase. It stays stable through every data-phase cycle.
- R8: For a read, `rsp_rdata` in the response cycle equals the `hrdata` value present at the completing edge.
- R9: `hresp` = 1 (ERROR) at the completing edge gives `rsp_abort` = 1 in the response cycle only. A good response gives 0.
- R10: A local access or a buffered write with `wb_full` = 0 is accepted in its first cycle, whatever `hclk_en` and `hready` are. It raises `tcm_sel` or `wb_push` respectively in that cycle.
- R11: A buffered write holds `core_en` at 0 and `wb_push` at 0 while `wb_full` = 1. It is accepted in the first cycle with `wb_full` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hclk_en | input | 1 | High in a cycle whose closing edge is a bus-clock edge |
| req_valid | input | 1 | Core request present |
| req_local | input | 1 | Request targets local tightly-coupled memory |
| req_write | input | 1 | Request is a write |
| req_buf | input | 1 | Write may go through the write buffer |
| req_addr | input | AW | Request address |
| req_size | input | 3 | Transfer size code |
| req_prot | input | 4 | Protection code |
| req_wdata | input | DW | Write data |
| wb_full | input | 1 | Write buffer has no room |
| core_en | output | 1 | Core clock enable; 0 stalls the core |
| rsp_rdata | output | DW | Read data returned to the core |
| rsp_abort | output | 1 | Bus error returned to the core |
| wb_push | output | 1 | Hand the write to the write buffer |
| tcm_sel | output | 1 | Select local memory |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type |
| hwrite | output | 1 | Bus write direction |
| hsize | output | 3 | Bus transfer size |
| hprot | output | 4 | Bus protection |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Slave ready |
| hresp | input | 1 | Slave response, 1 = ERROR |

## Verification
The bench builds the block with its default widths, AW = 32 and DW = 32. The clock ratio is a bench variable rather than a parameter, so one build covers ratios of 1:1, 2:1 and 4:1, each combined with slave waits of 0 to 3. Different idle gaps before each request move its arrival phase, so the synchronization wait d takes every value from 0 to N−1. That brings the whole stall formula of R6 into reach, along with error responses and the write-buffer-full stall.

// File: rtl/ahbce_pkg.sv
package ahbce_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_ADDR,
    ST_DATA,
    ST_RESP
  } xfer_st_e;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_LOCAL,
    RK_BUFWR,
    RK_AHB
  } req_kind_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  // Stalled core cycles for one bus transfer.
  function automatic int unsigned stall_len(input int unsigned sync_wait,
                                            input int unsigned ratio,
                                            input int unsigned waits);
    return sync_wait + 1 + ratio * (waits + 2);
  endfunction

endpackage

// File: rtl/ahbce_req_classify.sv
module ahbce_req_classify
  import ahbce_pkg::*;
(
  input  logic      req_valid,
  input  logic      req_local,
  input  logic      req_write,
  input  logic      req_buf,
  output req_kind_e kind
);

  always_comb begin
    if (!req_valid)                kind = RK_NONE;
    else if (req_local)            kind = RK_LOCAL;
    else if (req_write && req_buf) kind = RK_BUFWR;
    else                           kind = RK_AHB;
  end

endmodule

// File: rtl/ahbce_xfer_fsm.sv
module ahbce_xfer_fsm
  import ahbce_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hclk_en,
  input  logic      hready,
  input  logic      wb_full,
  input  req_kind_e kind,
  output xfer_st_e  st_o,
  output logic      load_addr,
  output logic      addr_acc,
  output logic      xfer_done,
  output logic      core_en,
  output logic      wb_push,
  output logic      tcm_sel
);

  xfer_st_e st, nxt;
  logic     bus_edge_ready;

  assign bus_edge_ready = hclk_en & hready;
  assign st_o = st;

  always_comb begin
    nxt       = st;
    load_addr = 1'b0;
    addr_acc  = 1'b0;
    xfer_done = 1'b0;
    case (st)
      ST_IDLE: if (kind == RK_AHB) begin
        if (hclk_en) begin
          nxt       = ST_ADDR;
          load_addr = 1'b1;
        end else begin
          nxt = ST_SYNC;
        end
      end
      ST_SYNC: if (hclk_en) begin
        nxt       = ST_ADDR;
        load_addr = 1'b1;
      end
      ST_ADDR: if (bus_edge_ready) begin
        nxt      = ST_DATA;
        addr_acc = 1'b1;
      end
      ST_DATA: if (bus_edge_ready) begin
        nxt       = ST_RESP;
        xfer_done = 1'b1;
      end
      ST_RESP: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  logic idle_free;
  assign idle_free = (st == ST_IDLE) && (kind != RK_AHB) &&
                     !((kind == RK_BUFWR) && wb_full);
  assign core_en = idle_free || (st == ST_RESP);
  assign wb_push = (st == ST_IDLE) && (kind == RK_BUFWR) && !wb_full;
  assign tcm_sel = (st == ST_IDLE) && (kind == RK_LOCAL);

  // R6: a pending request stays in sync until a bus edge arrives
  p_sync_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC && !hclk_en) |=> (st == ST_SYNC));

  // R4: the data phase persists until hready and the enable coincide
  p_done_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !(hclk_en && hready)) |=> (st == ST_DATA));

  // R5: the response cycle lasts exactly one cycle
  p_resp_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RESP) |=> (st == ST_IDLE));

endmodule

// File: rtl/ahbce_bus_regs.sv
module ahbce_bus_regs
  import ahbce_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hclk_en,
  input  logic          in_data,
  input  logic          load_addr,
  input  logic          addr_acc,
  input  logic          xfer_done,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [2:0]    req_size,
  input  logic [3:0]    req_prot,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hresp,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [3:0]    hprot,
  output logic [DW-1:0] hwdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_abort
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr     <= '0;
      htrans    <= TR_IDLE;
      hwrite    <= 1'b0;
      hsize     <= '0;
      hprot     <= '0;
      hwdata    <= '0;
      rsp_rdata <= '0;
      rsp_abort <= 1'b0;
    end else begin
      if (load_addr) begin
        haddr  <= req_addr;
        hwrite <= req_write;
        hsize  <= req_size;
        hprot  <= req_prot;
        htrans <= TR_NONSEQ;
      end else if (addr_acc) begin
        htrans <= TR_IDLE;
      end
      if (addr_acc && hwrite) hwdata <= req_wdata;
      if (xfer_done && !hwrite) rsp_rdata <= hrdata;
      rsp_abort <= xfer_done & hresp;
    end
  end

  // R2: bus transfer type only moves on a bus-clock edge
  p_htrans_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != $past(htrans)) |-> $past(hclk_en));

  // R7: write data holds across the data phase
  p_hwdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && $past(in_data)) |-> $stable(hwdata));

  // R9: abort is a single-cycle flag
  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |=> !rsp_abort);

endmodule

// File: rtl/ahb_ce_master.sv
module ahb_ce_master
  import ahbce_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hclk_en,
  input  logic          req_valid,
  input  logic          req_local,
  input  logic          req_write,
  input  logic          req_buf,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [3:0]    req_prot,
  input  logic [DW-1:0] req_wdata,
  input  logic          wb_full,
  output logic          core_en,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_abort,
  output logic          wb_push,
  output logic          tcm_sel,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [3:0]    hprot,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  input  logic          hresp
);

  req_kind_e kind_w;
  xfer_st_e  st_w;
  logic      load_addr_w, addr_acc_w, xfer_done_w, in_data_w;

  assign in_data_w = (st_w == ST_DATA);

  ahbce_req_classify u_classify (
    .req_valid (req_valid),
    .req_local (req_local),
    .req_write (req_write),
    .req_buf   (req_buf),
    .kind      (kind_w)
  );

  ahbce_xfer_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hclk_en   (hclk_en),
    .hready    (hready),
    .wb_full   (wb_full),
    .kind      (kind_w),
    .st_o      (st_w),
    .load_addr (load_addr_w),
    .addr_acc  (addr_acc_w),
    .xfer_done (xfer_done_w),
    .core_en   (core_en),
    .wb_push   (wb_push),
    .tcm_sel   (tcm_sel)
  );

  ahbce_bus_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hclk_en   (hclk_en),
    .in_data   (in_data_w),
    .load_addr (load_addr_w),
    .addr_acc  (addr_acc_w),
    .xfer_done (xfer_done_w),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_size  (req_size),
    .req_prot  (req_prot),
    .req_wdata (req_wdata),
    .hrdata    (hrdata),
    .hresp     (hresp),
    .haddr     (haddr),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hprot     (hprot),
    .hwdata    (hwdata),
    .rsp_rdata (rsp_rdata),
    .rsp_abort (rsp_abort)
  );

  // R5: a bus request outside its response cycle keeps the core stalled
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_w == RK_AHB && st_w != ST_RESP) |-> !core_en);

  // R10: local access in idle is never held
  p_local_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_w == RK_LOCAL && st_w == ST_IDLE) |-> core_en);

  // R11: nothing pushed into a full write buffer
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_push |-> !wb_full);

endmodule

// File: tb/ahb_ce_master_tb_top.sv
module ahb_ce_master_tb_top;

  localparam logic [31:0] RD_KEY = 32'h5A5A_0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hclk_en = 1'b1;
  logic        req_valid = 1'b0, req_local = 1'b0, req_write = 1'b0, req_buf = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0]  req_size = '0;
  logic [3:0]  req_prot = '0;
  logic        wb_full = 1'b0;
  logic        core_en, rsp_abort, wb_push, tcm_sel, hwrite;
  logic [31:0] rsp_rdata, haddr, hwdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize;
  logic [3:0]  hprot;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1, hresp = 1'b0;

  always #5 clk = ~clk;

  ahb_ce_master dut_i (
    .clk(clk), .rst_n(rst_n), .hclk_en(hclk_en),
    .req_valid(req_valid), .req_local(req_local), .req_write(req_write),
    .req_buf(req_buf), .req_addr(req_addr), .req_size(req_size),
    .req_prot(req_prot), .req_wdata(req_wdata), .wb_full(wb_full),
    .core_en(core_en), .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort),
    .wb_push(wb_push), .tcm_sel(tcm_sel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata),
    .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus-clock enable generator: ratio is a run-time knob
  int ratio = 1;
  int cnt = 0;
  initial forever begin
    @(posedge clk);
    begin
      automatic int nx = (cnt + 1) % ratio;
      cnt     <= nx;
      hclk_en <= (nx == ratio - 1);
    end
  end

  // expected transfer attributes and slave behaviour
  int          cur_ws = 0;
  bit          cur_err = 0;
  logic [31:0] exp_addr = '0, exp_wdata = '0;
  logic        exp_write = 1'b0;
  logic [2:0]  exp_size = '0;
  logic [3:0]  exp_prot = '0;

  // slave model: decides at the falling edge, applies at the rising edge
  initial begin
    bit          sl_busy = 0, sl_wr = 0;
    int          sl_wait = 0;
    logic [1:0]  prev_tr = 2'b00;
    logic        prev_en = 1'b1;
    forever begin
      logic        n_ready, n_resp;
      logic [31:0] n_rdata;
      bit          n_busy, n_wr;
      int          n_wait;
      @(negedge clk); #3;
      n_ready = hready; n_resp = hresp; n_rdata = hrdata;
      n_busy = sl_busy; n_wr = sl_wr; n_wait = sl_wait;
      if (rst_n) begin
        if (htrans !== prev_tr)
          chk(prev_en === 1'b1, "R2 htrans moved after non-enabled cycle",
              {31'd0, prev_en}, 32'd1);
        if (sl_busy) begin
          chk(htrans === 2'b00, "R3 htrans back to IDLE in data phase",
              {30'd0, htrans}, 32'd0);
          if (sl_wr)
            chk(hwdata === exp_wdata, "R7 hwdata in data phase", hwdata, exp_wdata);
        end
        if (hclk_en && hready) begin
          if (sl_busy) begin n_busy = 0; n_resp = 1'b0; end
          if (htrans === 2'b10) begin
            chk(haddr === exp_addr, "R3 haddr", haddr, exp_addr);
            chk(hwrite === exp_write, "R3 hwrite", {31'd0, hwrite}, {31'd0, exp_write});
            chk(hsize === exp_size && hprot === exp_prot, "R3 hsize/hprot",
                {25'd0, hsize, hprot}, {25'd0, exp_size, exp_prot});
            n_busy  = 1; n_wr = hwrite; n_wait = cur_ws;
            n_ready = (cur_ws == 0); n_resp = cur_err;
            n_rdata = haddr ^ RD_KEY;
          end
        end else if (hclk_en && !hready) begin
          n_wait  = sl_wait - 1;
          n_ready = (n_wait == 0);
        end
      end
      prev_tr = htrans; prev_en = hclk_en;
      @(posedge clk);
      hready <= n_ready; hresp <= n_resp; hrdata <= n_rdata;
      sl_busy = n_busy; sl_wr = n_wr; sl_wait = n_wait;
    end
  end

  // scoreboard
  typedef struct {
    int          stall;
    bit          is_rd;
    logic [31:0] rdata;
    bit          abort;
  } exp_t;
  exp_t q[$];

  initial begin
    int stall = 0;
    bit post_chk = 0;
    forever begin
      @(negedge clk); #2;
      if (post_chk) begin
        chk(rsp_abort === 1'b0, "R9 abort lasts one cycle", {31'd0, rsp_abort}, 32'd0);
        post_chk = 0;
      end
      if (rst_n && req_valid) begin
        if (!core_en) stall++;
        else begin
          exp_t e;
          if (q.size() == 0) begin
            chk(0, "R5 acceptance without expected item", 32'd1, 32'd0);
          end else begin
            e = q.pop_front();
            chk(stall == e.stall, "R6 (R4, R5, R11) stall length", stall, e.stall);
            if (e.is_rd && !e.abort)
              chk(rsp_rdata === e.rdata, "R8 read data", rsp_rdata, e.rdata);
            chk(rsp_abort === e.abort, "R9 abort flag", {31'd0, rsp_abort}, {31'd0, e.abort});
            post_chk = 1;
          end
          stall = 0;
        end
      end
    end
  end

  // driver
  task automatic run_req(input bit loc, input bit wr, input bit bufd,
                         input logic [31:0] a, input logic [31:0] wd,
                         input int ws, input bit err, input int full_cyc);
    exp_t e;
    bit   ahb;
    int   d;
    @(negedge clk);
    ahb = !loc && !(wr && bufd);
    d   = hclk_en ? 0 : (ratio - 1 - cnt);
    cur_ws = ws; cur_err = err;
    exp_addr = a; exp_write = wr; exp_wdata = wd;
    exp_size = 3'd2 ^ a[4:2]; exp_prot = a[7:4];
    e.stall = ahb ? (d + 1 + ratio * (ws + 2)) : full_cyc;
    e.is_rd = ahb && !wr;
    e.rdata = a ^ RD_KEY;
    e.abort = ahb && err;
    q.push_back(e);
    req_local = loc; req_write = wr; req_buf = bufd;
    req_addr = a; req_wdata = wd; req_size = exp_size; req_prot = exp_prot;
    wb_full = (full_cyc > 0);
    req_valid = 1'b1;
    if (full_cyc > 0) begin
      #1;
      chk(wb_push === 1'b0 && core_en === 1'b0, "R11 full buffer holds write",
          {30'd0, wb_push, core_en}, 32'd0);
      repeat (full_cyc) @(negedge clk);
      wb_full = 1'b0;
    end
    #1;
    while (!core_en) begin @(negedge clk); #1; end
    if (loc) chk(tcm_sel === 1'b1, "R10 tcm_sel on local access", {31'd0, tcm_sel}, 32'd1);
    if (!loc && wr && bufd)
      chk(wb_push === 1'b1, "R10 wb_push on buffered write", {31'd0, wb_push}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    int idx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(core_en === 1'b1, "R1 core_en after reset", {31'd0, core_en}, 32'd1);
    chk(htrans === 2'b00, "R1 htrans IDLE after reset", {30'd0, htrans}, 32'd0);
    chk(rsp_abort === 1'b0, "R1 abort clear after reset", {31'd0, rsp_abort}, 32'd0);

    for (int ri = 0; ri < 3; ri++) begin
      @(negedge clk);
      ratio = (ri == 0) ? 1 : (ri == 1) ? 2 : 4;
      repeat (8) @(negedge clk);
      for (int ws = 0; ws < 4; ws++) begin
        for (int rw = 0; rw < 2; rw++) begin
          repeat ((ws + rw + idx) % 4) @(negedge clk);
          run_req(0, rw[0], 0, 32'h0000_1000 + idx * 36, 32'hC0DE_0000 + idx,
                  ws, 0, 0);
          idx++;
        end
      end
      // R9: error responses
      run_req(0, 0, 0, 32'h0000_2040 + ri * 16, 32'd0, 1, 1, 0);
      run_req(0, 1, 0, 32'h0000_2084 + ri * 16, 32'hBAD0_0000 + ri, 0, 1, 0);
      // R10: local and buffered accesses never wait on the bus
      run_req(1, 0, 0, 32'h0000_3000, 32'd0, 3, 0, 0);
      run_req(0, 1, 1, 32'h0000_3010, 32'h1234_5678, 3, 0, 0);
      // R11: buffered write while the buffer is full
      run_req(0, 1, 1, 32'h0000_3020, 32'h8765_4321, 0, 0, 3);
    end
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R5 every request answered", q.size(), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule